// File: doc/BRIEF.md
# Double-Buffered Symmetric Activation Table

This block evaluates either the logistic sigmoid or the hyperbolic tangent of a signed 16-bit fixed-point input by reading a precomputed table. Each table covers only non-negative inputs. A negative input is folded onto its magnitude, and the result is then rebuilt from the symmetry of the function: sigmoid(-x) = 1 - sigmoid(x), and tanh(-x) = -tanh(x). Inputs whose magnitude lies past the end of the table return the value of the function's asymptote.

Two complete table buffers sit side by side. Each buffer is split into an even bank and an odd bank. Software fills the buffers through a load port before it issues lookups. A typical use keeps the sigmoid table in one buffer and the tanh table in the other, so that a change of function costs no reload. The other typical use refills one buffer while the second one keeps serving lookups. Every lookup carries its own buffer select and its own function tag. The function tag only chooses the symmetry rule, so either buffer can serve either function.

Top module: `actLut`

## Requirements
- R1: While reset is asserted, and right after it, `outValid` is 0 and `outY` is 0.
- R2: A cycle with `loadEn`=1 writes `loadData` into entry `loadAddr` of buffer `loadBuf` (0 or 1). Even and odd entries both store and read back, and a later lookup with that buffer select sees the new value.
- R3: For an input magnitude |x| below 4096, the table index is |x| >> 4. The four low bits are dropped, so |x| = 4095 uses entry 255.
- R4: For x >= 0 inside the range, `outY` equals the addressed table entry, whatever the function tag.
- R5: For a negative x with the sigmoid tag (`inFunc`=0), `outY` = 16384 - entry(|x|), where 16384 is 1.0 with 14 fraction bits.
- R6: For a negative x with the tanh tag (`inFunc`=1), `outY` is the two's complement negation of entry(|x|).
- R7: When |x| >= 4096, including x = -32768, the table is not read for the result. Sigmoid gives 16384 for positive x and 0 for negative x. Tanh gives 16384 for positive x and -16384 for negative x.
- R8: A lookup sampled at a rising edge with `inValid`=1 produces exactly one `outValid` pulse with its result, visible after the following rising edge. Cycles without a lookup produce no `outValid`. Back-to-back lookups give back-to-back results.
- R9: A load into one buffer in the same cycle as a lookup served from the other buffer does not change that lookup's result.
- R10: A load into the same buffer entry that a lookup reads in the same cycle leaves that lookup with the old value. The next lookup returns the new value.
- R11: The function tag and the buffer select are independent. Alternating the function or the buffer on consecutive lookups returns the correct result for each lookup, with no stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| loadEn | input | 1 | Write one table entry this cycle |
| loadBuf | input | 1 | Buffer that receives the write |
| loadAddr | input | 8 | Table entry index (magnitude index) |
| loadData | input | 16 | Unsigned table value, 14 fraction bits |
| inValid | input | 1 | Lookup request this cycle |
| inX | input | 16 | Signed input value |
| inBuf | input | 1 | Buffer that serves the lookup |
| inFunc | input | 1 | Function tag: 0 sigmoid, 1 tanh |
| outValid | output | 1 | Result valid |
| outY | output | 16 | Signed result, 14 fraction bits |

## Verification
The two buffers are filled with different ramps. Because the ramps differ, a read from the wrong buffer, from the wrong bank or at an index shifted by one shows up as a wrong value. Directed lookups cover zero, the same index reached from several low-bit patterns, both signs under each function tag, the last in-range magnitude, the first out-of-range magnitude, and the most negative code. Together they separate the fold logic, the index extraction and the saturation path. Same-cycle loads into the other buffer, and into the very entry being read, separate buffer isolation from read-before-write ordering. A pseudo-random sweep then mixes functions, buffers, idle cycles and loads, with every result compared against a behavioural model.

// File: rtl/actLutPkg.sv
package actLutPkg;

  localparam int NUM_BUF  = 2;
  localparam int NUM_BANK = 2;

  typedef enum logic {
    FN_SIGMOID = 1'b0,
    FN_TANH    = 1'b1
  } actFunc_e;

  typedef struct packed {
    logic [NUM_BUF-1:0][NUM_BANK-1:0] bankWe;
    logic                             rdEn;
    logic                             valid;
    logic                             neg;
    actFunc_e                         func;
    logic                             sat;
    logic                             selBuf;
    logic                             bank;
  } lutStrobes_t;

endpackage

// File: rtl/actBank.sv
module actBank #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read returns the contents from before a same-cycle write.
  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/actCtrl.sv
module actCtrl
  import actLutPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int RANGE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadBuf,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inX,
  input  logic              inBuf,
  input  actFunc_e          inFunc,
  output lutStrobes_t       stb,
  output logic [ADDR_W-2:0] wrAddr,
  output logic [ADDR_W-2:0] rdAddr
);

  localparam int SHIFT = RANGE_W - ADDR_W;
  localparam logic [DATA_W-1:0] RANGE_LIMIT = {{(DATA_W-1){1'b0}}, 1'b1} << RANGE_W;

  logic [DATA_W-1:0] magFull;
  logic [ADDR_W-1:0] idx;
  logic              overRange;

  logic     s1Valid, s1Neg, s1Sat, s1Buf, s1Bank;
  actFunc_e s1Func;

  always_comb begin
    magFull   = inX[DATA_W-1] ? (~inX + 1'b1) : inX;
    overRange = (magFull >= RANGE_LIMIT);
    idx       = magFull[RANGE_W-1:SHIFT];
    rdAddr    = idx[ADDR_W-1:1];
    wrAddr    = loadAddr[ADDR_W-1:1];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Neg   <= 1'b0;
      s1Sat   <= 1'b0;
      s1Buf   <= 1'b0;
      s1Bank  <= 1'b0;
      s1Func  <= FN_SIGMOID;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Neg  <= inX[DATA_W-1];
        s1Sat  <= overRange;
        s1Buf  <= inBuf;
        s1Bank <= idx[0];
        s1Func <= inFunc;
      end
    end
  end

  always_comb begin
    stb = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      for (int k = 0; k < NUM_BANK; k++) begin
        stb.bankWe[b][k] = loadEn && (loadBuf == 1'(b)) && (loadAddr[0] == 1'(k));
      end
    end
    stb.rdEn   = inValid;
    stb.valid  = s1Valid;
    stb.neg    = s1Neg;
    stb.func   = s1Func;
    stb.sat    = s1Sat;
    stb.selBuf = s1Buf;
    stb.bank   = s1Bank;
  end

  // R2: a load touches at most one bank of one buffer
  assert_one_bank_write_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb.bankWe));

  // R8: every lookup request enters the tag pipeline
  assert_lookup_tagged_R8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> stb.valid);

endmodule

// File: rtl/actDatapath.sv
module actDatapath
  import actLutPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  lutStrobes_t       stb,
  input  logic [ADDR_W-2:0] wrAddr,
  input  logic [OUT_W-1:0]  wrData,
  input  logic [ADDR_W-2:0] rdAddr,
  output logic              outValid,
  output logic [OUT_W-1:0]  outY
);

  localparam int BANK_AW = ADDR_W - 1;
  localparam logic [OUT_W-1:0] ONE     = {{(OUT_W-1){1'b0}}, 1'b1} << FRAC_W;
  localparam logic [OUT_W-1:0] NEG_ONE = ~ONE + 1'b1;

  logic [OUT_W-1:0] bankData [NUM_BUF][NUM_BANK];
  logic [OUT_W-1:0] tblVal, posVal, result;

  for (genvar b = 0; b < NUM_BUF; b++) begin : gBuf
    for (genvar k = 0; k < NUM_BANK; k++) begin : gBank
      actBank #(.AW(BANK_AW), .DW(OUT_W)) uBank (
        .clk    (clk),
        .we     (stb.bankWe[b][k]),
        .wrAddr (wrAddr),
        .wrData (wrData),
        .rdEn   (stb.rdEn),
        .rdAddr (rdAddr),
        .rdData (bankData[b][k])
      );
    end
  end

  always_comb begin
    tblVal = bankData[stb.selBuf][stb.bank];
    posVal = stb.sat ? ONE : tblVal;
    if (!stb.neg)                result = posVal;
    else if (stb.func == FN_TANH) result = ~posVal + 1'b1;
    else                          result = ONE - posVal;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      outValid <= 1'b0;
      outY     <= '0;
    end else begin
      outValid <= stb.valid;
      if (stb.valid) outY <= result;
    end
  end

  // R7: positive out-of-range input lands on +1.0
  assert_sat_positive_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && stb.sat && !stb.neg) |=> (outY == ONE));

  // R7: negative out-of-range tanh lands on -1.0
  assert_sat_neg_tanh_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && stb.sat && stb.neg && stb.func == FN_TANH) |=> (outY == NEG_ONE));

  // R7: negative out-of-range sigmoid lands on 0
  assert_sat_neg_sigmoid_R7: assert property (@(posedge clk) disable iff (rst)
    (stb.valid && stb.sat && stb.neg && stb.func == FN_SIGMOID) |=> (outY == '0));

endmodule

// File: rtl/actLut.sv
module actLut
  import actLutPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int RANGE_W = 12,
  parameter int OUT_W   = 16,
  parameter int FRAC_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadBuf,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [OUT_W-1:0]  loadData,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inX,
  input  logic              inBuf,
  input  logic              inFunc,
  output logic              outValid,
  output logic [OUT_W-1:0]  outY
);

  lutStrobes_t       stb;
  logic [ADDR_W-2:0] wrAddr, rdAddr;
  actFunc_e          funcTag;

  assign funcTag = actFunc_e'(inFunc);

  actCtrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RANGE_W(RANGE_W)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .loadEn   (loadEn),
    .loadBuf  (loadBuf),
    .loadAddr (loadAddr),
    .inValid  (inValid),
    .inX      (inX),
    .inBuf    (inBuf),
    .inFunc   (funcTag),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr)
  );

  actDatapath #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .wrData   (loadData),
    .rdAddr   (rdAddr),
    .outValid (outValid),
    .outY     (outY)
  );

  // R8: a result appears only for a lookup two edges earlier
  assert_result_has_request_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  // R8: every lookup yields a result two edges later
  assert_request_has_result_R8: assert property (@(posedge clk) disable iff (rst)
    $past(inValid, 2) |-> outValid);

endmodule

// File: tb/actLut_test.sv
`timescale 1ns/1ps
module actLut_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0, loadBuf = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic        inValid = 1'b0, inBuf = 1'b0, inFunc = 1'b0;
  logic [15:0] inX = '0;
  logic        outValid;
  logic [15:0] outY;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] model [2][256];

  bit          pendV = 0;
  logic [15:0] pendY = '0;
  string       pendTag = "";

  always #2 clk = ~clk;

  actLut uut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadBuf(loadBuf), .loadAddr(loadAddr),
    .loadData(loadData), .inValid(inValid), .inX(inX), .inBuf(inBuf), .inFunc(inFunc),
    .outValid(outValid), .outY(outY)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refVal(input logic [15:0] x, input bit b, input bit f);
    int xs, mag, pos, y;
    xs  = $signed(x);
    mag = (xs < 0) ? -xs : xs;
    if (mag >= 4096) pos = 16384;
    else pos = model[b][mag >> 4];
    if (xs >= 0) y = pos;
    else if (f) y = -pos;
    else y = 16384 - pos;
    return y[15:0];
  endfunction

  // One clock: drive, let the edge happen, update the model, compare outputs.
  task automatic cyc(input bit le, input bit lb, input int la, input int ld,
                     input bit iv, input int ix, input bit ib, input bit fn,
                     input string tag);
    logic [15:0] newY;
    @(negedge clk);
    loadEn = le; loadBuf = lb; loadAddr = la[7:0]; loadData = ld[15:0];
    inValid = iv; inX = ix[15:0]; inBuf = ib; inFunc = fn;
    @(posedge clk);
    newY = refVal(ix[15:0], ib, fn);
    if (le) model[lb][la[7:0]] = ld[15:0];
    #1;
    check(outValid == pendV, {pendTag, " R8 valid"}, outValid, pendV);
    if (pendV) check(outY == pendY, pendTag, $signed(outY), $signed(pendY));
    pendV = iv; pendY = newY; pendTag = tag;
  endtask

  task automatic look(input int ix, input bit ib, input bit fn, input string tag);
    cyc(0, 0, 0, 0, 1, ix, ib, fn, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid in reset", outValid, 0);
    check(outY == 16'd0, "R1 data in reset", outY, 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid after reset", outValid, 0);
    check(outY == 16'd0, "R1 data after reset", outY, 0);

    // R2: fill both buffers with distinct ramps, even and odd entries alike
    for (int a = 0; a < 256; a++) cyc(1, 0, a, 8192 + a * 32, 0, 0, 0, 0, "R2 load0");
    for (int a = 0; a < 256; a++) cyc(1, 1, a, a * 60, 0, 0, 0, 0, "R2 load1");

    look(0, 0, 0, "R4 zero");
    look(80, 0, 0, "R3 idx5");
    look(95, 0, 0, "R3 low bits dropped");
    look(81, 1, 1, "R4 tanh positive odd");
    look(-80, 0, 0, "R5 negative sigmoid");
    look(-95, 0, 0, "R5 negative sigmoid low bits");
    look(-80, 1, 1, "R6 negative tanh");
    look(-4095, 1, 1, "R6 last entry");
    look(4095, 0, 0, "R3 last entry");
    look(4096, 0, 0, "R7 first over range sigmoid");
    look(-4096, 0, 0, "R7 negative sigmoid sat");
    look(-4096, 1, 1, "R7 negative tanh sat");
    look(-32768, 1, 1, "R7 most negative tanh");
    look(-32768, 0, 0, "R7 most negative sigmoid");
    look(32767, 1, 1, "R7 max positive tanh");
    look(-160, 0, 1, "R11 tanh from buffer 0");
    look(-160, 1, 0, "R11 sigmoid from buffer 1");
    look(-160, 0, 0, "R11 alternate back");
    look(-160, 1, 1, "R11 alternate again");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");

    // R9: write buffer 1 entry 10 while reading buffer 0 entry 10
    cyc(1, 1, 10, 777, 1, 160, 0, 0, "R9 other buffer untouched");
    look(160, 1, 1, "R2 new value visible");
    // R10: write and read the same entry of the same buffer
    cyc(1, 0, 20, 5000, 1, 320, 0, 0, "R10 old value same cycle");
    look(320, 0, 0, "R10 new value next");
    cyc(1, 0, 21, 6001, 1, -336, 0, 1, "R10 odd entry old value");
    look(-336, 0, 1, "R10 odd entry new value");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int x;
      seed = seed * 1664525 + 1013904223;
      x = seed[20] ? int'($signed({{4{seed[11]}}, seed[11:0]})) : int'($signed(seed[15:0]));
      cyc(seed[30] & seed[29], seed[28], int'(seed[7:0]), int'(seed[27:14]),
          seed[31] | seed[25], x, seed[24], seed[23], "R4 sweep");
    end
    repeat (2) cyc(0, 0, 0, 0, 0, 0, 0, 0, "R8 flush");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule